// File: doc/BRIEF.md
# Configurable UART Transmit Channel

This block is the transmit half of an asynchronous serial port. Software writes a character into a single-entry holding buffer. When the channel is enabled, and the optional clear-to-send input allows it, the character moves into a shift register. From there it goes out on the serial line as a frame: one start bit, 7, 8 or 9 data bits, an optional odd or even parity bit, and one or two stop bits.

The bit period is set by an 8-bit reload divider. The divider counts ticks from either an internal prescaled clock-enable or the rising edges of an external clock pin, and each bit lasts 16 divider reloads. A one-cycle interrupt pulse can be placed at one of two points: when the buffer hands its character to the shift register, or when the last stop bit has been sent. The buffer empties at hand-off, so software can refill it while a frame is in flight and get frames with no idle gap between them.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `irq` is 0, and `txd` stays 1 whenever no frame is in progress.
- R2: A frame starts with one low start bit, followed by the data bits least significant first. The data length comes from control bits [2:1]: 00 gives 7 bits, 01 gives 8 bits, and 10 or 11 give 9 bits.
- R3: When control bit 3 is 1, a parity bit follows the data. Control bit 4 set to 1 selects odd parity, where the data bits plus the parity bit hold an odd number of ones. Control bit 4 set to 0 selects even parity. When control bit 3 is 0, no parity bit is sent.
- R4: The frame ends with stop bits at level 1: one stop bit when control bit 5 is 0, and two when it is 1. The line is idle at 1 in the cycle after the last stop bit.
- R5: Every bit lasts exactly 16×(m+1) source ticks, where m is the divider value.
- R6: When control bit 6 is 0, the source tick is `int_clk_en`. When it is 1, the source tick is each rising edge of `ext_clk`, taken after a two-stage synchronizer.
- R7: A frame starts only when control bit 0 (transmit enable) is 1 and the buffer holds a character (`buf_empty` = 0). While transmit enable is 0, a full buffer is held and `txd` stays 1.
- R8: When control bit 8 is 1, a frame starts only while the synchronized `cts_n` is 0. When control bit 8 is 0, `cts_n` has no effect.
- R9: `cts_n` is looked at only when a frame could start. A frame in progress completes even if `cts_n` rises.
- R10: `buf_empty` becomes 1 in the same cycle that the start bit appears. If the buffer was refilled during a frame and the start conditions hold, the next start bit follows the last stop bit with no idle cycle.
- R11: With control bit 7 = 0, `irq` is high for exactly one cycle: the first cycle of each start bit.
- R12: With control bit 7 = 1, `irq` is high for exactly one cycle: the cycle right after the last stop bit ends.
- R13: A write with `wr_addr` = 0 loads the control register. A write with `wr_addr` = 1 loads the divider m from `wr_data[7:0]`. A write with `wr_addr` = 2 loads `wr_data[8:0]` into the buffer and clears `buf_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 divider, 2 data |
| wr_data | input | 9 | Write data |
| int_clk_en | input | 1 | Internal prescaled clock enable (source tick) |
| ext_clk | input | 1 | External bit-rate clock, asynchronous |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer has no unsent character |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is the back-to-back hand-off. The buffer has to be refilled while a frame is still shifting, so that a second frame's start bit falls exactly where the previous last stop bit ends. In that same cycle the end-of-frame interrupt and the next load coincide. The bench writes the second character at a fixed offset inside the first frame. It then checks that the line is low in the very cycle after the last stop bit and that the interrupt pulse lands there. A second directed case raises `cts_n` in the middle of a frame, and random frames cover the data lengths, parity modes, stop counts and divider values.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA = 9;
  localparam int FRM_W    = MAX_DATA + 4;
  localparam int CNT_W    = $clog2(FRM_W + 1);

  // control register layout, bit 8 down to bit 0
  typedef struct packed {
    logic       cts_en;
    logic       int_sel;
    logic       ext_sel;
    logic       stop2;
    logic       par_odd;
    logic       par_en;
    logic [1:0] len;
    logic       tx_en;
  } ctl_t;

  function automatic int data_len(input logic [1:0] l);
    return (l == 2'd0) ? 7 : (l == 2'd1) ? 8 : 9;
  endfunction

  function automatic logic par_bit(input logic [MAX_DATA-1:0] d,
                                   input logic [1:0] l, input logic odd);
    logic x;
    int   n;
    x = 1'b0;
    n = data_len(l);
    for (int i = 0; i < MAX_DATA; i++)
      if (i < n) x ^= d[i];
    return odd ? ~x : x;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input ctl_t c);
    return CNT_W'(2 + data_len(c.len) + int'(c.par_en) + int'(c.stop2));
  endfunction

  function automatic logic [FRM_W-1:0] build_frame(input logic [MAX_DATA-1:0] d,
                                                   input ctl_t c);
    logic [FRM_W-1:0] f;
    int n;
    n = data_len(c.len);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < n) f[i+1] = d[i];
    if (c.par_en) f[n+1] = par_bit(d, c.len, c.par_odd);
    return f;
  endfunction
endpackage

// File: rtl/uart_clk_src.sv
module uart_clk_src (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic int_clk_en,
  input  logic ext_clk,
  output logic src_tick
);
  logic [2:0] ext_sync;
  logic       ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk};
  end

  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign src_tick = ext_sel ? ext_rise : int_clk_en;
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_m,
  output logic             bit_tick
);
  localparam int SUB_W = $clog2(OVS);

  logic [DIV_W-1:0] div_cnt;
  logic [SUB_W-1:0] sub_cnt;
  logic             sub_tick;

  assign sub_tick = src_tick && (div_cnt == '0);
  assign bit_tick = sub_tick && (sub_cnt == SUB_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sub_cnt <= '0;
    end else if (restart) begin
      div_cnt <= div_m;
      sub_cnt <= '0;
    end else if (src_tick) begin
      if (div_cnt == '0) begin
        div_cnt <= div_m;
        sub_cnt <= (sub_cnt == SUB_W'(OVS - 1)) ? '0 : sub_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt - 1'b1;
      end
    end
  end

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (div_cnt == $past(div_m)) && (sub_cnt == '0));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FRM_W-1:0] frame_in,
  input  logic [CNT_W-1:0] nbits,
  input  logic             bit_tick,
  output logic             txd,
  output logic             busy,
  output logic             frame_done
);
  logic [FRM_W-1:0] shreg;
  logic [CNT_W-1:0] left;

  assign frame_done = busy && bit_tick && (left == CNT_W'(1));
  assign txd        = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= frame_in;
      left  <= nbits;
      busy  <= 1'b1;
    end else if (busy && bit_tick) begin
      shreg <= {1'b1, shreg[FRM_W-1:1]};
      left  <= left - 1'b1;
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !frame_done |=> busy);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  // R4
  last_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> txd);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16,
  parameter int WR_W  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [WR_W-1:0] wr_data,
  input  logic            int_clk_en,
  input  logic            ext_clk,
  input  logic            cts_n,
  output logic            txd,
  output logic            buf_empty,
  output logic            irq
);
  ctl_t                ctl;
  logic [DIV_W-1:0]    div_m;
  logic [MAX_DATA-1:0] buf_data;
  logic [1:0]          cts_sync;
  logic                cts_ok, start_ok, load_go, data_wr;
  logic                src_tick, bit_tick, busy, frame_done;

  assign data_wr  = wr_en && (wr_addr == 2'd2);
  assign cts_ok   = !ctl.cts_en || !cts_sync[1];
  assign start_ok = ctl.tx_en && !buf_empty && cts_ok;
  assign load_go  = start_ok && (!busy || frame_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      div_m     <= '0;
      buf_data  <= '0;
      buf_empty <= 1'b1;
      irq       <= 1'b0;
      cts_sync  <= 2'b11;
    end else begin
      cts_sync <= {cts_sync[0], cts_n};
      irq      <= ctl.int_sel ? frame_done : load_go;
      if (wr_en && wr_addr == 2'd0) ctl   <= ctl_t'(wr_data[8:0]);
      if (wr_en && wr_addr == 2'd1) div_m <= wr_data[DIV_W-1:0];
      if (data_wr) begin
        buf_data  <= wr_data[MAX_DATA-1:0];
        buf_empty <= 1'b0;
      end else if (load_go) begin
        buf_empty <= 1'b1;
      end
    end
  end

  uart_clk_src u_src (
    .clk(clk), .rst_n(rst_n), .ext_sel(ctl.ext_sel),
    .int_clk_en(int_clk_en), .ext_clk(ext_clk), .src_tick(src_tick)
  );

  uart_baud_gen #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .restart(load_go),
    .div_m(div_m), .bit_tick(bit_tick)
  );

  uart_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_go),
    .frame_in(build_frame(buf_data, ctl)), .nbits(frame_len(ctl)),
    .bit_tick(bit_tick), .txd(txd), .busy(busy), .frame_done(frame_done)
  );

  // R7
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |-> ctl.tx_en && !buf_empty);
  // R8
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go && ctl.cts_en |-> !cts_sync[1]);
  // R10
  handoff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go && !data_wr |=> buf_empty);
  // R11
  irq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go && !ctl.int_sel |=> irq);
  // R12
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && ctl.int_sel |=> irq);
endmodule

// File: tb/tb_uart_tx_chan.sv
module tb_uart_tx_chan;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [8:0] wr_data = '0;
  logic       int_clk_en = 1'b1;
  logic       ext_run = 1'b0;
  logic [1:0] ext_div = '0;
  logic       cts_n = 1'b0;
  logic       txd, buf_empty, irq;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (ext_run) ext_div <= ext_div + 2'd1;

  uart_tx_chan dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .int_clk_en(int_clk_en), .ext_clk(ext_div[1]), .cts_n(cts_n),
    .txd(txd), .buf_empty(buf_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nlen(input int lc);
    return (lc == 0) ? 7 : (lc == 1) ? 8 : 9;
  endfunction

  function automatic int exp_bit(input logic [8:0] d, input int lc, pe, po, int k);
    int n, ones;
    n = nlen(lc);
    if (k == 0) return 0;
    if (k <= n) return int'(d[k-1]);
    k = k - n - 1;
    if (pe != 0) begin
      if (k == 0) begin
        ones = 0;
        for (int i = 0; i < n; i++) ones += int'(d[i]);
        return (po != 0) ? 1 - (ones % 2) : ones % 2;
      end
    end
    return 1;
  endfunction

  task automatic wreg(input logic [1:0] a, input logic [8:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [8:0] ctlw(input int txen, lc, pe, po, s2, ext, isel, ctsen);
    return {ctsen[0], isel[0], ext[0], s2[0], po[0], pe[0], lc[1:0], txen[0]};
  endfunction

  task automatic wait_start(input string req);
    int t;
    t = 0;
    while (txd !== 1'b0 && t < 200) begin @(negedge clk); t++; end
    chk(txd === 1'b0, req, int'(txd), 0);
  endtask

  // current negedge is offset 0 of the frame (start bit visible)
  task automatic observe(input logic [8:0] d, input int lc, pe, po, s2, m, isel, ext,
                         input int b2b, input logic [8:0] d2, input int cts_off,
                         input logic irq0);
    int p, nb, irq_bad;
    p = 16 * (m + 1) * ((ext != 0) ? 4 : 1);
    nb = 2 + nlen(lc) + pe + s2;
    irq_bad = 0;
    for (int o = 0; o < nb * p; o++) begin
      if (o > 0) @(negedge clk);
      if (o == 0) chk(irq === irq0, (isel != 0) ? "R12 irq at start" : "R11 irq at start",
                      int'(irq), int'(irq0));
      else if (irq !== 1'b0) irq_bad++;
      if (o == 1) chk(buf_empty === 1'b1, "R10 empty after hand-off", int'(buf_empty), 1);
      if (o == cts_off) cts_n = 1'b1;
      if (b2b != 0 && o == p) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = d2; end
      if (b2b != 0 && o == p + 1) wr_en = 1'b0;
      if (o % p == p / 2)
        chk(txd === exp_bit(d, lc, pe, po, o / p)[0], "R2 R3 R4 R5 R13 bit value",
            int'(txd), exp_bit(d, lc, pe, po, o / p));
    end
    chk(irq_bad == 0, "R11 R12 no stray irq", irq_bad, 0);
    @(negedge clk);
    if (b2b != 0) begin
      chk(txd === 1'b0, "R10 no idle gap", int'(txd), 0);
    end else if (ext != 0) begin
      repeat (8) @(negedge clk);
      chk(txd === 1'b1 && buf_empty === 1'b1, "R6 idle after ext frame", int'(txd), 1);
    end else begin
      chk(txd === 1'b1, "R4 idle after stop", int'(txd), 1);
      chk(irq === isel[0], "R12 irq after last stop", int'(irq), isel);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] d, d2;
    int lc, pe, po, s2, m, isel, ctsen, bad;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    chk(buf_empty === 1'b1, "R1 reset empty", int'(buf_empty), 1);
    chk(irq === 1'b0, "R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: transmit enable off holds the buffer (R7)
    wreg(2'd1, 9'd0);
    wreg(2'd0, ctlw(0, 1, 0, 0, 0, 0, 0, 0));
    wreg(2'd2, 9'h0A5);
    bad = 0;
    repeat (100) begin if (txd !== 1'b1) bad++; @(negedge clk); end
    chk(bad == 0 && buf_empty === 1'b0, "R7 held while disabled", bad, 0);
    wreg(2'd0, ctlw(1, 1, 0, 0, 0, 0, 0, 0));
    wait_start("R7 start once enabled");
    observe(9'h0A5, 1, 0, 0, 0, 0, 0, 0, 0, 9'd0, -1, 1'b1);

    // directed: CTS blocks start, then mid-frame rise is ignored (R8, R9)
    cts_n = 1'b1;
    wreg(2'd0, ctlw(1, 2, 1, 1, 1, 0, 0, 1));
    wreg(2'd2, 9'h1C3);
    bad = 0;
    repeat (100) begin if (txd !== 1'b1) bad++; @(negedge clk); end
    chk(bad == 0 && buf_empty === 1'b0, "R8 blocked by cts", bad, 0);
    cts_n = 1'b0;
    wait_start("R8 start on cts low");
    observe(9'h1C3, 2, 1, 1, 1, 0, 0, 0, 0, 9'd0, 40, 1'b1);
    chk(buf_empty === 1'b1, "R9 frame completed after cts rise", int'(buf_empty), 1);

    // directed: CTS disabled ignores a high cts_n (R8)
    wreg(2'd0, ctlw(1, 0, 1, 0, 0, 0, 1, 0));
    wreg(2'd2, 9'h07F);
    wait_start("R8 cts ignored when disabled");
    observe(9'h07F, 0, 1, 0, 0, 0, 1, 0, 0, 9'd0, -1, 1'b0);
    cts_n = 1'b0;

    // directed: back-to-back with end-of-frame irq (R10, R12)
    wreg(2'd1, 9'd1);
    wreg(2'd0, ctlw(1, 1, 1, 0, 0, 0, 1, 0));
    wreg(2'd2, 9'h033);
    wait_start("R10 first frame");
    observe(9'h033, 1, 1, 0, 0, 1, 1, 0, 1, 9'h0CC, -1, 1'b0);
    observe(9'h0CC, 1, 1, 0, 0, 1, 1, 0, 0, 9'd0, -1, 1'b1);

    // directed: external clock source (R6)
    ext_run = 1'b1;
    int_clk_en = 1'b0;
    wreg(2'd0, ctlw(1, 0, 0, 0, 0, 1, 0, 0));
    wreg(2'd2, 9'h055);
    wait_start("R6 ext start");
    observe(9'h055, 0, 0, 0, 0, 1, 0, 1, 0, 9'd0, -1, 1'b1);
    ext_run = 1'b0;
    int_clk_en = 1'b1;

    // random frames
    for (int t = 0; t < 24; t++) begin
      lc = int'($urandom_range(3, 0)); pe = int'($urandom_range(1, 0));
      po = int'($urandom_range(1, 0)); s2 = int'($urandom_range(1, 0));
      m = int'($urandom_range(3, 0));  isel = int'($urandom_range(1, 0));
      ctsen = int'($urandom_range(1, 0));
      d = 9'($urandom);
      d2 = d;
      wreg(2'd1, 9'(m));
      wreg(2'd0, ctlw(1, lc, pe, po, s2, 0, isel, ctsen));
      wreg(2'd2, d2);
      wait_start("R2 random start");
      observe(d, (lc == 3) ? 2 : lc, pe, po, s2, m, isel, 0, 0, 9'd0, -1,
              (isel == 0) ? 1'b1 : 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule